// File: doc/BRIEF.md
# Bounded LIFO Stack with Programmable Limits

This block is a last-in, first-out store of 16-bit words held in a 64-entry register array. A 6-bit stack pointer names the address of the item currently on top. A push first advances the pointer by one, wrapping modulo 64, and then writes the new word at the advanced address. A pop reads the word under the pointer and then moves the pointer back by one. Software sets a floor register and a ceiling register through a separate load port. The unit compares the pointer with the ceiling after every push to find the full state, and with the floor after every pop to find the empty state.

Requests enter on a valid/ready interface. `push_valid` and `pop_valid` share the single `req_ready`, and a request is consumed in any cycle where its valid and `req_ready` are both high. Popped words leave on a second valid/ready interface, `rd_valid`/`rd_ready`. While a popped word waits with `rd_ready` low, `req_ready` is low and the word and its valid are held. `req_ready` is also low in any cycle where the limit registers are being loaded. A request that cannot be served is still consumed. It changes nothing and raises `err` for one cycle. The live stack occupies addresses floor+1 up to the pointer, taken modulo 64. Its capacity is ((ceiling − floor − 1) mod 64) + 1, so equal limits give all 64 words.

Top module: `stk_unit`

## Requirements
- R1: While reset is held, and after it, `sp` is 0, `empty` is 1, and `full`, `err` and `rd_valid` are 0. Both the floor and the ceiling are 0.
- R2: An accepted push (push_valid=1, pop_valid=0, req_ready=1) with `full`=0 sets `sp` to sp+1 mod 64 and stores `push_data` at that new address. It also clears `empty`.
- R3: After an accepted push that was not rejected, `full` is 1 exactly when the new `sp` equals the ceiling. An accepted pop clears `full`. `full` and `empty` are never both 1.
- R4: An accepted pop (pop_valid=1, push_valid=0, req_ready=1) with `empty`=0 puts the word stored at `sp` on `rd_data`, with `rd_valid`=1, in the next cycle. It also sets `sp` to sp−1 mod 64.
- R5: After an accepted pop that was not rejected, `empty` is 1 exactly when the new `sp` equals the floor.
- R6: An accepted push while `full`=1 leaves `sp`, the flags and the stored words unchanged. It makes `err` 1 for the next cycle only.
- R7: An accepted pop while `empty`=1 leaves `sp` and the flags unchanged and produces no `rd_valid`. It makes `err` 1 for the next cycle only.
- R8: An accepted request with both `push_valid` and `pop_valid` at 1 is a no-operation: `sp`, the flags and the stored words stay as they were, `err` stays 0, and no word is returned.
- R9: `lim_we`=1 loads the floor from `lim_lo` and the ceiling from `lim_hi`. In the next cycle `sp` equals the new floor, `empty` is 1 and `full` is 0. `req_ready` is 0 while `lim_we` is 1.
- R10: `req_ready` is 1 exactly when `lim_we`=0 and no popped word is waiting (rd_valid=0 or rd_ready=1). A waiting word keeps `rd_valid` and `rd_data` stable until `rd_ready` is 1.
- R11: With both limits at 0, the first push lands at address 1. After 64 pushes `sp` is 0 and `full` is 1, and popping all 64 words returns them in reverse order of pushing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request |
| push_data | input | 16 | Word to push |
| pop_valid | input | 1 | Pop request |
| req_ready | output | 1 | Request accepted in this cycle when high |
| rd_valid | output | 1 | Popped word available |
| rd_ready | input | 1 | Consumer takes the popped word |
| rd_data | output | 16 | Popped word |
| lim_we | input | 1 | Load floor and ceiling registers |
| lim_lo | input | 6 | New floor (lower limit) |
| lim_hi | input | 6 | New ceiling (upper limit) |
| sp | output | 6 | Stack pointer, address of top item |
| full | output | 1 | Stack holds its capacity |
| empty | output | 1 | Stack holds no item |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench fills the default 64-word stack so that the pointer wraps through 63 back to 0. A design that compares limits at the wrong moment, or that confuses full with empty when both limits are equal, would raise `full` early or report `empty` while 64 words are held. It pushes into a full stack and pops from an empty one. These checks catch a design that moves the pointer, overwrites a word or emits `rd_valid` on a rejected request. It also holds `rd_ready` low after a pop, which exposes a design that keeps accepting requests or changes the held word. Further checks cover simultaneous push and pop, and limits that wrap across address 0 and are reloaded mid-stream. These expose a design that acts on one half of a combined request, or that keeps stale flags after a limit load.

// File: rtl/stk_pkg.sv
package stk_pkg;
  // One decoded action per cycle
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_PUSH = 2'd1,
    ACT_POP  = 2'd2,
    ACT_LOAD = 2'd3
  } act_e;
endpackage

// File: rtl/stk_ptr_ctl.sv
module stk_ptr_ctl
  import stk_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  act_e          act,
  input  logic [AW-1:0] new_lo,
  input  logic [AW-1:0] new_hi,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] wr_addr,
  output logic          full_q,
  output logic          empty_q,
  output logic          err_q,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [AW-1:0] floor_q, ceil_q;
  logic [AW-1:0] sp_up, sp_dn;
  logic          reject;

  assign sp_up   = sp_q + AW'(1);
  assign sp_dn   = sp_q - AW'(1);
  assign wr_addr = sp_up;
  assign push_ok = (act == ACT_PUSH) && !full_q;
  assign pop_ok  = (act == ACT_POP) && !empty_q;
  assign reject  = ((act == ACT_PUSH) && full_q) || ((act == ACT_POP) && empty_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      floor_q <= '0;
      ceil_q  <= '0;
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= reject;
      if (act == ACT_LOAD) begin
        floor_q <= new_lo;
        ceil_q  <= new_hi;
        sp_q    <= new_lo;
        full_q  <= 1'b0;
        empty_q <= 1'b1;
      end else if (push_ok) begin
        sp_q    <= sp_up;
        full_q  <= (sp_up == ceil_q);
        empty_q <= 1'b0;
      end else if (pop_ok) begin
        sp_q    <= sp_dn;
        empty_q <= (sp_dn == floor_q);
        full_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stk_store.sv
module stk_store #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/stk_rd_out.sv
module stk_rd_out #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          stall
);
  assign stall = rd_valid && !rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (load) begin
      rd_valid <= 1'b1;
      rd_data  <= din;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_valid,
  output logic          req_ready,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  input  logic          lim_we,
  input  logic [AW-1:0] lim_lo,
  input  logic [AW-1:0] lim_hi,
  output logic [AW-1:0] sp,
  output logic          full,
  output logic          empty,
  output logic          err
);
  act_e          act;
  logic          stall, push_ok, pop_ok;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] top_word;

  assign req_ready = !lim_we && !stall;

  // Simultaneous push and pop decodes to idle
  always_comb begin
    act = ACT_IDLE;
    if (lim_we)                                      act = ACT_LOAD;
    else if (req_ready && push_valid && !pop_valid)  act = ACT_PUSH;
    else if (req_ready && pop_valid && !push_valid)  act = ACT_POP;
  end

  stk_ptr_ctl #(.AW(AW)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .new_lo  (lim_lo),
    .new_hi  (lim_hi),
    .sp_q    (sp),
    .wr_addr (wr_addr),
    .full_q  (full),
    .empty_q (empty),
    .err_q   (err),
    .push_ok (push_ok),
    .pop_ok  (pop_ok)
  );

  stk_store #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (push_ok),
    .waddr (wr_addr),
    .wdata (push_data),
    .raddr (sp),
    .rdata (top_word)
  );

  stk_rd_out #(.DW(DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pop_ok),
    .din      (top_word),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .stall    (stall)
  );
endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          pop_valid,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          lim_we,
  input logic [AW-1:0] lim_lo,
  input logic [AW-1:0] lim_hi,
  input logic [AW-1:0] sp,
  input logic          full,
  input logic          empty,
  input logic          err
);
  logic          take_push, take_pop, take_both;
  logic [AW-1:0] ceil_sh;

  assign take_push = req_ready && push_valid && !pop_valid;
  assign take_pop  = req_ready && pop_valid && !push_valid;
  assign take_both = req_ready && push_valid && pop_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)      ceil_sh <= '0;
    else if (lim_we) ceil_sh <= lim_hi;
  end

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_push && !full |=> (sp == $past(sp) + AW'(1)) && !empty);

  p_full_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_push && !full |=> full == (sp == ceil_sh));

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_pop && !empty |=> rd_valid && (sp == $past(sp) - AW'(1)) && !full);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_push && full |=> err && $stable(sp) && full);

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_pop && empty |=> err && !rd_valid && $stable(sp) && empty);

  p_both_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_both |=> !err && $stable(sp) && $stable(full) && $stable(empty));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lim_we |=> empty && !full && (sp == $past(lim_lo)));

  p_load_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lim_we |-> !req_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |-> !req_ready);
endmodule

bind stk_unit stk_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .pop_valid  (pop_valid),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .lim_we     (lim_we),
  .lim_lo     (lim_lo),
  .lim_hi     (lim_hi),
  .sp         (sp),
  .full       (full),
  .empty      (empty),
  .err        (err)
);

// File: tb/stk_unit_tb_top.sv
module stk_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_valid = 1'b0, pop_valid = 1'b0, rd_ready = 1'b1, lim_we = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [AW-1:0] lim_lo = '0, lim_hi = '0;
  logic          req_ready, rd_valid, full, empty, err;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_unit #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop_valid(pop_valid), .req_ready(req_ready), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .lim_we(lim_we), .lim_lo(lim_lo),
    .lim_hi(lim_hi), .sp(sp), .full(full), .empty(empty), .err(err)
  );

  // Reference model state
  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_sp = '0, m_lo = '0, m_hi = '0;
  logic          m_full = 1'b0, m_empty = 1'b1, m_rv = 1'b0, m_err = 1'b0;
  logic [DW-1:0] m_rd = '0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_ready(bit we, bit rdy);
    return !we && (!m_rv || rdy);
  endfunction

  task automatic step(bit psh, bit pp, logic [DW-1:0] d, bit rdy,
                      bit we = 1'b0, logic [AW-1:0] lo = '0, logic [AW-1:0] hi = '0);
    string tag;
    bit    rq;
    @(negedge clk);
    push_valid = psh; pop_valid = pp; push_data = d; rd_ready = rdy;
    lim_we = we; lim_lo = lo; lim_hi = hi;
    #1;
    rq = exp_ready(we, rdy);
    chk("R10", "req_ready", int'(req_ready), int'(rq));
    tag = "R10";
    m_err = 1'b0;
    if (m_rv && rdy) m_rv = 1'b0;
    if (we) begin
      tag = "R9";
      m_lo = lo; m_hi = hi; m_sp = lo; m_empty = 1'b1; m_full = 1'b0;
    end else if (rq && psh && pp) begin
      tag = "R8";
    end else if (rq && psh) begin
      if (m_full) begin
        tag = "R6"; m_err = 1'b1;
      end else begin
        tag = "R2";
        m_sp = m_sp + AW'(1); m_mem[m_sp] = d;
        m_full = (m_sp == m_hi); m_empty = 1'b0;
      end
    end else if (rq && pp) begin
      if (m_empty) begin
        tag = "R7"; m_err = 1'b1;
      end else begin
        tag = "R4";
        m_rd = m_mem[m_sp]; m_rv = 1'b1;
        m_sp = m_sp - AW'(1);
        m_empty = (m_sp == m_lo); m_full = 1'b0;
      end
    end
    @(posedge clk);
    #1;
    chk(tag, "sp", int'(sp), int'(m_sp));
    chk("R3", "full", int'(full), int'(m_full));
    chk("R5", "empty", int'(empty), int'(m_empty));
    chk(tag, "err", int'(err), int'(m_err));
    chk(tag, "rd_valid", int'(rd_valid), int'(m_rv));
    if (m_rv) chk(tag, "rd_data", int'(rd_data), int'(m_rd));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "sp", int'(sp), 0);
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "err", int'(err), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R11: default limits 0/0, fill all 64 words with wrap
    step(1, 0, 16'hA000, 1);
    chk("R11", "first push address", int'(sp), 1);
    for (int i = 1; i < DEPTH; i++) step(1, 0, 16'hA000 + DW'(i), 1);
    chk("R11", "sp after 64 pushes", int'(sp), 0);
    chk("R11", "full after 64 pushes", int'(full), 1);
    step(1, 0, 16'hDEAD, 1);          // R6 rejected push
    step(1, 1, 16'hBEEF, 1);          // R8 both together
    // R10 back-pressure: pop then hold rd_ready low
    step(0, 1, '0, 1);
    step(0, 1, '0, 0);
    step(0, 1, '0, 0);
    for (int i = 1; i < DEPTH; i++) step(0, 1, '0, 1);
    chk("R11", "last popped word", int'(rd_data), 16'hA000);
    step(0, 1, '0, 1);                // R7 rejected pop
    step(0, 0, '0, 1);

    // R9 load small window, capacity 3
    step(0, 0, '0, 1, 1'b1, 6'd10, 6'd13);
    for (int i = 0; i < 4; i++) step(1, 0, 16'h1100 + DW'(i), 1);
    for (int i = 0; i < 4; i++) step(0, 1, '0, 1);
    // Window wrapping across address 0, capacity 16
    step(0, 0, '0, 1, 1'b1, 6'd50, 6'd2);
    for (int i = 0; i < 17; i++) step(1, 0, 16'h2200 + DW'(i), 1);
    step(0, 1, '0, 1);
    // Reload while items present
    step(0, 0, '0, 1, 1'b1, 6'd0, 6'd0);

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit psh, pp, rdy, we;
      r = int'($urandom_range(99));
      psh = (r < 50) || (r >= 95);
      pp  = (r >= 45);
      rdy = ($urandom_range(99) < 75);
      we  = ($urandom_range(199) == 0);
      step(psh, pp, DW'($urandom), rdy, we, AW'($urandom), AW'($urandom));
    end

    done = 1'b1;
    finish_run();
  end
endmodule